// File: doc/BRIEF.md
# Nonvolatile Memory Word-Sum Checksum Engine

This block walks the leading words of a word-addressed nonvolatile memory through a narrow read port, adds them with 16-bit wraparound, and compares the result against a fixed signature value of 0xBABA. It has two modes. In verify mode it gives a pass or mismatch verdict. In update mode it computes the word that makes the region sum to the signature, and it stores that word with one write to the checksum slot.

A controller raises `start_i` for one cycle and selects the mode with `mode_i`. The engine then holds `busy_o` high. It issues one read at a time, in strictly ascending address order, and waits for each read to end in valid data or an error before it sends the next. When the operation ends, `done_o` pulses for one cycle with a status code on `status_o` and a result word on `sum_o`. Any read error stops the run at once. A write error is reported as its own status.

The control states are:
- IDLE: waiting for a start.
- ISSUE: the read request pulse.
- WAIT: waiting for the read to return data or an error.
- WRITE: the write request pulse.
- WRWAIT: waiting for the write acknowledge or error.
- DONE: the completion pulse.

The transitions are:
- IDLE to ISSUE on a start, or IDLE to WRITE for an update when the checksum index is zero.
- ISSUE to WAIT.
- WAIT back to ISSUE on data when more words remain.
- WAIT to WRITE on the last data in update mode.
- WAIT to DONE on the last data in verify mode, or on a read error.
- WRITE to WRWAIT.
- WRWAIT to DONE on an acknowledge or an error.
- DONE to IDLE.

Top module: `nvm_sum_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_req_o` and `wr_req_o` are all low.
- R2: A start is accepted only while both `busy_o` and `done_o` are low. `busy_o` rises in the next cycle and stays high until the cycle in which `done_o` is raised. A start pulse given while busy has no effect: it causes no extra reads, no write and no extra done.
- R3: Each read request is a one-cycle pulse. The first read of a run is at address 0, and each later read is at the previous address plus one. No read is issued while an earlier read still waits for `rd_valid_i` or `rd_err_i`.
- R4: Verify mode (`mode_i`=0) reads words 0 through CHECKSUM_IDX inclusive. It finishes with status 0 (pass) when their 16-bit sum equals 0xBABA and with status 1 (mismatch) otherwise. `sum_o` then carries the sum.
- R5: Update mode (`mode_i`=1) reads words 0 through CHECKSUM_IDX-1. It then issues exactly one write to address CHECKSUM_IDX with data 0xBABA minus their sum. After the acknowledge it finishes with status 0, and `sum_o` carries the written word.
- R6: A read error ends the run in the cycle after it is sampled, with status 2. No further read and no write follow it.
- R7: A write error ends the run in the cycle after it is sampled, with status 3.
- R8: `done_o` is high for exactly one cycle, with `busy_o` low. `status_o` and `sum_o` keep their values after done until the next run changes them.
- R9: All sums and differences wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start request |
| mode_i | input | 1 | 0 = verify, 1 = update; sampled with the start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok/pass, 1 mismatch, 2 read error, 3 write error |
| sum_o | output | 16 | Verify: computed sum; update: written word |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | AW | Read word address |
| rd_valid_i | input | 1 | Read data valid |
| rd_err_i | input | 1 | Read failed |
| rd_data_i | input | 16 | Read data |
| wr_req_o | output | 1 | Write request pulse |
| wr_addr_o | output | AW | Write word address (checksum slot) |
| wr_data_o | output | 16 | Write data |
| wr_ack_i | input | 1 | Write completed |
| wr_err_i | input | 1 | Write failed |

## Verification
The read request appears one cycle after an accepted start, and one cycle after each valid response that is not the last. `done_o` comes one cycle after the final read response, the read error or the write response. In update mode the write pulse comes one cycle after the last read data. The bench's memory model samples requests at the falling edge and answers a configurable number of cycles later, so every design reaction is observed at the falling edge that follows the rising edge where it was registered. The scoreboard pops the expected status and word whenever `done_o` is seen, and checks at the next falling edge that done has fallen and the status is held.

// File: rtl/nvm_sum_pkg.sv
package nvm_sum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE,
        ST_WRWAIT,
        ST_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        STS_OK       = 2'd0,
        STS_MISMATCH = 2'd1,
        STS_RD_ERR   = 2'd2,
        STS_WR_ERR   = 2'd3
    } eng_status_t;

    localparam logic MODE_VERIFY = 1'b0;
    localparam logic MODE_UPDATE = 1'b1;

endpackage

// File: rtl/nvm_sum_accum.sv
module nvm_sum_accum #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          add_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] sum_o,
    output logic [DW-1:0] sum_next_o
);
    // Wraps naturally at DW bits.
    assign sum_next_o = sum_o + word_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o <= '0;
        end else if (clear_i) begin
            sum_o <= '0;
        end else if (add_i) begin
            sum_o <= sum_next_o;
        end
    end
endmodule

// File: rtl/nvm_sum_addr.sv
module nvm_sum_addr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    input  logic [AW-1:0] limit_i,
    output logic [AW-1:0] addr_o,
    output logic          at_limit_o
);
    assign at_limit_o = (addr_o == limit_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (clear_i) begin
            addr_o <= '0;
        end else if (step_i) begin
            addr_o <= addr_o + 1'b1;
        end
    end
endmodule

// File: rtl/nvm_sum_verdict.sv
module nvm_sum_verdict #(
    parameter int          DW        = 16,
    parameter logic [15:0] SIGNATURE = 16'hBABA
) (
    input  logic [DW-1:0] total_i,
    output logic          match_o,
    output logic [DW-1:0] fix_o
);
    localparam logic [DW-1:0] SIG_W = DW'(SIGNATURE);

    assign match_o = (total_i == SIG_W);
    assign fix_o   = SIG_W - total_i;
endmodule

// File: rtl/nvm_sum_engine.sv
module nvm_sum_engine
    import nvm_sum_pkg::*;
#(
    parameter int          AW           = 8,
    parameter int          DW           = 16,
    parameter int          CHECKSUM_IDX = 8'h3F,
    parameter logic [15:0] SIGNATURE    = 16'hBABA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    status_o,
    output logic [DW-1:0] sum_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic          rd_err_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_req_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_ack_i,
    input  logic          wr_err_i
);
    localparam logic [AW-1:0] IDX_W    = AW'(CHECKSUM_IDX);
    localparam bit            UPD_SKIP = (CHECKSUM_IDX == 0);
    localparam logic [AW-1:0] LIM_VER  = IDX_W;
    localparam logic [AW-1:0] LIM_UPD  = UPD_SKIP ? '0 : AW'(CHECKSUM_IDX - 1);
    localparam logic [DW-1:0] SIG_W    = DW'(SIGNATURE);

    eng_state_t  state_q, state_d;
    eng_status_t status_q;
    logic        mode_q;
    logic [DW-1:0] result_q;

    logic          start_ok;
    logic          rd_ok;
    logic          acc_clear, acc_add;
    logic          addr_step;
    logic [DW-1:0] acc_sum, acc_next;
    logic [AW-1:0] limit;
    logic          at_limit;
    logic          sig_match;
    logic [DW-1:0] fix_word;

    assign start_ok  = (state_q == ST_IDLE) && start_i;
    assign rd_ok     = (state_q == ST_WAIT) && rd_valid_i && !rd_err_i;
    assign acc_clear = start_ok;
    assign acc_add   = rd_ok;
    assign addr_step = rd_ok && !at_limit;
    assign limit     = (mode_q == MODE_UPDATE) ? LIM_UPD : LIM_VER;

    nvm_sum_accum #(.DW(DW)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (acc_clear),
        .add_i      (acc_add),
        .word_i     (rd_data_i),
        .sum_o      (acc_sum),
        .sum_next_o (acc_next)
    );

    nvm_sum_addr #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (acc_clear),
        .step_i     (addr_step),
        .limit_i    (limit),
        .addr_o     (rd_addr_o),
        .at_limit_o (at_limit)
    );

    nvm_sum_verdict #(.DW(DW), .SIGNATURE(SIGNATURE)) u_verdict (
        .total_i (acc_next),
        .match_o (sig_match),
        .fix_o   (fix_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (mode_i == MODE_UPDATE && UPD_SKIP) begin
                        state_d = ST_WRITE;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (rd_err_i) begin
                    state_d = ST_DONE;
                end else if (rd_valid_i) begin
                    if (!at_limit) begin
                        state_d = ST_ISSUE;
                    end else if (mode_q == MODE_UPDATE) begin
                        state_d = ST_WRITE;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_WRITE: state_d = ST_WRWAIT;
            ST_WRWAIT: begin
                if (wr_err_i || wr_ack_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Result and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_VERIFY;
            status_q <= STS_OK;
            result_q <= '0;
        end else begin
            if (start_ok) begin
                mode_q <= mode_i;
                if (mode_i == MODE_UPDATE && UPD_SKIP) begin
                    result_q <= SIG_W;
                end
            end
            if (state_q == ST_WAIT) begin
                if (rd_err_i) begin
                    status_q <= STS_RD_ERR;
                    result_q <= acc_sum;
                end else if (rd_valid_i && at_limit) begin
                    if (mode_q == MODE_UPDATE) begin
                        result_q <= fix_word;
                    end else begin
                        result_q <= acc_next;
                        status_q <= sig_match ? STS_OK : STS_MISMATCH;
                    end
                end
            end
            if (state_q == ST_WRWAIT) begin
                if (wr_err_i) begin
                    status_q <= STS_WR_ERR;
                end else if (wr_ack_i) begin
                    status_q <= STS_OK;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o   = 1'b0;
        done_o   = 1'b0;
        rd_req_o = 1'b0;
        wr_req_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE:  begin busy_o = 1'b1; rd_req_o = 1'b1; end
            ST_WAIT:   busy_o = 1'b1;
            ST_WRITE:  begin busy_o = 1'b1; wr_req_o = 1'b1; end
            ST_WRWAIT: busy_o = 1'b1;
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
    end

    assign status_o  = status_q;
    assign sum_o     = result_q;
    assign wr_addr_o = IDX_W;
    assign wr_data_o = result_q;

endmodule

// File: rtl/nvm_sum_checker.sv
module nvm_sum_checker #(
    parameter int AW           = 8,
    parameter int CHECKSUM_IDX = 8'h3F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [1:0]    status_o,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_valid_i,
    input logic          rd_err_i,
    input logic          wr_req_o,
    input logic [AW-1:0] wr_addr_o,
    input logic          wr_ack_i,
    input logic          wr_err_i
);
    logic          rd_pend, wr_pend, rd_seen;
    logic [AW-1:0] rd_last;
    logic          accept;

    assign accept = start_i && !busy_o && !done_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
            rd_seen <= 1'b0;
            rd_last <= '0;
        end else begin
            if (rd_req_o) begin
                rd_pend <= 1'b1;
            end else if (rd_valid_i || rd_err_i) begin
                rd_pend <= 1'b0;
            end
            if (wr_req_o) begin
                wr_pend <= 1'b1;
            end else if (wr_ack_i || wr_err_i) begin
                wr_pend <= 1'b0;
            end
            if (accept) begin
                rd_seen <= 1'b0;
            end else if (rd_req_o) begin
                rd_seen <= 1'b1;
                rd_last <= rd_addr_o;
            end
        end
    end

    p_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !rd_pend);

    p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_seen) |-> (rd_addr_o == '0));

    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_seen) |-> (rd_addr_o == rd_last + 1'b1));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_write_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (wr_addr_o == AW'(CHECKSUM_IDX)));

    p_rd_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && rd_err_i) |=> (done_o && status_o == 2'd2));

    p_wr_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && wr_err_i) |=> (done_o && status_o == 2'd3));

endmodule

bind nvm_sum_engine nvm_sum_checker #(
    .AW           (AW),
    .CHECKSUM_IDX (CHECKSUM_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .status_o   (status_o),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .rd_err_i   (rd_err_i),
    .wr_req_o   (wr_req_o),
    .wr_addr_o  (wr_addr_o),
    .wr_ack_i   (wr_ack_i),
    .wr_err_i   (wr_err_i)
);

// File: tb/sim_nvm_sum_engine.sv
`timescale 1ns/1ps
module sim_nvm_sum_engine;
    localparam int          AW  = 8;
    localparam int          IDX = 63;
    localparam logic [15:0] SIG = 16'hBABA;

    logic          clk;
    logic          rst_n;
    logic          start_i, mode_i;
    logic          busy_o, done_o;
    logic [1:0]    status_o;
    logic [15:0]   sum_o;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i, rd_err_i;
    logic [15:0]   rd_data_i;
    logic          wr_req_o;
    logic [AW-1:0] wr_addr_o;
    logic [15:0]   wr_data_o;
    logic          wr_ack_i, wr_err_i;

    nvm_sum_engine #(.AW(AW), .DW(16), .CHECKSUM_IDX(IDX), .SIGNATURE(SIG)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .sum_o(sum_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_err_i(rd_err_i), .rd_data_i(rd_data_i), .wr_req_o(wr_req_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
        .wr_err_i(wr_err_i)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    typedef struct {
        logic [1:0]  st;
        logic [15:0] val;
        bit          chk_val;
        string       req;
    } exp_t;

    exp_t        expq[$];
    logic [15:0] mem [0:255];
    int          rd_lat = 1, wr_lat = 1, rd_err_at = -1;
    bit          wr_fail = 0;
    int          rd_cnt = 0, wr_cnt = 0, wr_addr_seen = -1;
    int          done_cnt = 0;
    int          total = 0, bad = 0;
    bit          finished = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sum_to(int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    // Read responder
    initial begin
        int rwait = 0;
        int raddr = 0;
        rd_valid_i = 0; rd_err_i = 0; rd_data_i = '0;
        forever begin
            @(negedge clk);
            rd_valid_i = 0; rd_err_i = 0;
            if (rwait > 0) begin
                rwait--;
                if (rwait == 0) begin
                    if (raddr == rd_err_at) rd_err_i = 1;
                    else begin rd_valid_i = 1; rd_data_i = mem[raddr]; end
                end
            end else if (rd_req_o) begin
                raddr = int'(rd_addr_o);
                check(raddr == rd_cnt, "R3", "read address order", raddr, rd_cnt);
                rd_cnt++;
                rwait = rd_lat + 1;
            end
        end
    end

    // Write responder
    initial begin
        int wwait = 0;
        int waddr = 0;
        logic [15:0] wdata = '0;
        wr_ack_i = 0; wr_err_i = 0;
        forever begin
            @(negedge clk);
            wr_ack_i = 0; wr_err_i = 0;
            if (wwait > 0) begin
                wwait--;
                if (wwait == 0) begin
                    if (wr_fail) wr_err_i = 1;
                    else begin wr_ack_i = 1; mem[waddr] = wdata; end
                end
            end else if (wr_req_o) begin
                waddr = int'(wr_addr_o);
                wdata = wr_data_o;
                wr_addr_seen = waddr;
                wr_cnt++;
                wwait = wr_lat + 1;
            end
        end
    end

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done_o) begin
                exp_t e;
                done_cnt++;
                check(!busy_o, "R8", "busy during done", int'(busy_o), 0);
                if (expq.size() == 0) begin
                    check(0, "R2", "unexpected done", 1, 0);
                end else begin
                    e = expq.pop_front();
                    check(status_o == e.st, e.req, "status", int'(status_o), int'(e.st));
                    if (e.chk_val)
                        check(sum_o == e.val, e.req, "result word", int'(sum_o), int'(e.val));
                    @(negedge clk);
                    check(!done_o, "R8", "done width", int'(done_o), 0);
                    check(status_o == e.st, "R8", "status held", int'(status_o), int'(e.st));
                end
            end
        end
    end

    task automatic run_op(bit mode, string req, bit extra_start);
        exp_t e;
        int   d0;
        int   exp_rd, exp_wr;
        logic [15:0] s;
        e.req = req;
        e.chk_val = 1;
        if (mode == 1'b0) begin
            s = sum_to(IDX + 1);
            e.st = (s == SIG) ? 2'd0 : 2'd1;
            e.val = s;
            exp_rd = IDX + 1;
            exp_wr = 0;
        end else begin
            s = sum_to(IDX);
            e.val = SIG - s;
            e.st = wr_fail ? 2'd3 : 2'd0;
            exp_rd = IDX;
            exp_wr = 1;
        end
        if (rd_err_at >= 0) begin
            e.st = 2'd2; e.chk_val = 0; exp_rd = rd_err_at + 1; exp_wr = 0;
        end
        expq.push_back(e);
        rd_cnt = 0; wr_cnt = 0; wr_addr_seen = -1;
        d0 = done_cnt;
        start_i = 1; mode_i = mode;
        @(negedge clk);
        start_i = 0;
        check(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
        if (extra_start) begin
            repeat (10) @(negedge clk);
            start_i = 1; mode_i = ~mode;
            @(negedge clk);
            start_i = 0;
        end
        wait (done_cnt > d0);
        repeat (3) @(negedge clk);
        check(done_cnt == d0 + 1, "R2", "done count", done_cnt - d0, 1);
        check(rd_cnt == exp_rd, (rd_err_at >= 0) ? "R6" : "R3", "read count", rd_cnt, exp_rd);
        check(wr_cnt == exp_wr, (mode && rd_err_at < 0) ? "R5" : "R6", "write count", wr_cnt, exp_wr);
        if (exp_wr == 1)
            check(wr_addr_seen == IDX, "R5", "write address", wr_addr_seen, IDX);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "WDOG", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        start_i = 0; mode_i = 0; rst_n = 0;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h1111 + 7);
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!busy_o, "R1", "busy after reset", int'(busy_o), 0);
        check(!done_o, "R1", "done after reset", int'(done_o), 0);
        check(!rd_req_o, "R1", "rd_req after reset", int'(rd_req_o), 0);
        check(!wr_req_o, "R1", "wr_req after reset", int'(wr_req_o), 0);

        // Verify on unbalanced data: mismatch expected
        run_op(1'b0, "R4", 0);
        // Update, then verify passes; zero latency
        rd_lat = 0; wr_lat = 0;
        run_op(1'b1, "R5", 0);
        check(mem[IDX] == SIG - sum_to(IDX), "R5", "stored word", int'(mem[IDX]), int'(SIG - sum_to(IDX)));
        run_op(1'b0, "R4", 0);
        // Wraparound: all ones
        rd_lat = 3; wr_lat = 2;
        for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
        run_op(1'b0, "R9", 0);
        run_op(1'b1, "R9", 0);
        run_op(1'b0, "R9", 0);
        // Start while busy is ignored
        mem[3] = 16'h1234;
        run_op(1'b0, "R2", 1);
        // Read errors
        rd_err_at = 5;
        run_op(1'b0, "R6", 0);
        rd_err_at = 0;
        run_op(1'b1, "R6", 0);
        rd_err_at = -1;
        // Write error: stored word stays unchanged
        wr_fail = 1;
        mem[IDX] = 16'h0F0F;
        run_op(1'b1, "R7", 0);
        check(mem[IDX] == 16'h0F0F, "R7", "slot untouched", int'(mem[IDX]), 16'h0F0F);
        wr_fail = 0;
        // Recover with a normal update
        rd_lat = 1;
        run_op(1'b1, "R5", 0);
        run_op(1'b0, "R4", 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule